// File: doc/BRIEF.md
# Dual-Loop Digital Lock Detector

This block decides whether each of two phase-locked loops has settled. It runs on the crystal oscillator clock and, for every reference period, measures how many oscillator cycles separate the reference edge from the divided-VCO edge of each loop. The measurement starts at whichever of the two edges arrives first. A comparison counts as good when the gap is under three oscillator periods. A loop counts as locked once it has seen a run of fifteen good comparisons in a row. While a loop is measuring, it also raises a pump request. The request is "up" when the VCO edge lags the reference and "down" when it leads.

The two loop verdicts are merged into one pin that models an open-drain output. The pin value is low, and it is actually driven only while every enabled loop is locked. A disabled (powered-down) loop takes no part in the merged decision. If both loops are off, the pin is left floating. All edge inputs are one-cycle pulses that are already synchronous to the oscillator clock. The block has no data stream, so every pin is plain control or status, with no handshake and no back-pressure.

Top module: `dual_lock_detect`

## Requirements
- R1: After reset, `lock_oe` is 0, `lock_n` is 1, and every `pump_up` and `pump_dn` bit is 0.
- R2: When a loop's reference pulse arrives first, its `pump_up` is 1 (and `pump_dn` is 0) in every cycle after that pulse, up to and including the cycle in which the VCO pulse is sampled.
- R3: When a loop's VCO pulse arrives first, its `pump_dn` is 1 (and `pump_up` is 0) in every cycle after that pulse, up to and including the cycle in which the reference pulse is sampled.
- R4: Reference and VCO pulses sampled on the same clock edge give a good comparison of zero error, and neither pump bit rises.
- R5: The error is the number of clock edges from the first pulse to the second. An error of 0, 1 or 2 is good. An error of 3 or more is bad.
- R6: A loop is locked once its most recent 15 comparisons are all good. After 14 good comparisons it is not yet locked.
- R7: A bad comparison clears the loop's run of good comparisons at once. The loop's lock is gone from the second clock edge after the edge that closes that comparison.
- R8: The run count saturates at 15. Any number of further good comparisons keeps the loop locked.
- R9: If the second pulse has not come within 8 clock edges of the first (the window), the comparison is bad, and the pump request drops after the 8th edge.
- R10: `lock_oe` is 1 exactly when at least one loop is enabled and every enabled loop is locked. `lock_n` is 0 when `lock_oe` is 1, and 1 otherwise. A disabled loop is ignored, and with both loops disabled `lock_oe` is 0.
- R11: A disabled loop ignores its edge pulses: no pump request and no comparison. Its run count is cleared, so after it is re-enabled it needs 15 fresh good comparisons to lock again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Crystal oscillator clock; measures phase error |
| rst_n | input | 1 | Active-low asynchronous reset |
| loop_en | input | 2 | Per-loop enable; 0 means the loop is powered down |
| ref_edge | input | 2 | Per-loop one-cycle reference edge pulse |
| vco_edge | input | 2 | Per-loop one-cycle divided-VCO edge pulse |
| pump_up | output | 2 | Per-loop source-current request (VCO lags) |
| pump_dn | output | 2 | Per-loop sink-current request (VCO leads) |
| lock_n | output | 1 | Lock pin value, low when all enabled loops are locked |
| lock_oe | output | 1 | Drive enable of the lock pin; 0 means high impedance |

## Verification
Each pump bit changes in the cycle right after the clock edge that samples a pulse. The pump request also clears right after the edge that samples the closing pulse or the 8th timeout edge. The comparison verdict is registered on that closing edge, and the run count takes it on the following edge, so `lock_oe` and `lock_n` are due after the second edge past the closing pulse. A change of `loop_en` shows on `lock_oe` within the same cycle. The bench drives pulses just after a falling edge and reads outputs at falling edges. It checks the pump bits at every falling edge of the measurement window, and checks the lock pin at the falling edge two rising edges after the close.

// File: rtl/pld_pkg.sv
package pld_pkg;
  typedef enum logic [1:0] {
    PH_IDLE     = 2'd0,
    PH_WAIT_VCO = 2'd1,
    PH_WAIT_REF = 2'd2
  } ph_state_e;

  typedef struct packed {
    logic valid;
    logic good;
  } cmp_res_t;
endpackage

// File: rtl/pld_phase_meter.sv
module pld_phase_meter
  import pld_pkg::*;
#(
  parameter int ERR_LIMIT = 3,
  parameter int WIN       = 8
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     en,
  input  logic     ref_edge,
  input  logic     vco_edge,
  output logic     pump_up,
  output logic     pump_dn,
  output cmp_res_t cmp
);
  localparam int CW = $clog2(WIN + 1);

  ph_state_e     state, state_nxt;
  logic [CW-1:0] cnt, cnt_nxt;
  logic          done, good;

  always_comb begin
    state_nxt = state;
    cnt_nxt   = cnt;
    done      = 1'b0;
    good      = 1'b0;
    unique case (state)
      PH_IDLE: begin
        if (ref_edge && vco_edge) begin
          done = 1'b1;
          good = 1'b1;
        end else if (ref_edge) begin
          state_nxt = PH_WAIT_VCO;
          cnt_nxt   = CW'(1);
        end else if (vco_edge) begin
          state_nxt = PH_WAIT_REF;
          cnt_nxt   = CW'(1);
        end
      end
      PH_WAIT_VCO, PH_WAIT_REF: begin
        if ((state == PH_WAIT_VCO) ? vco_edge : ref_edge) begin
          done      = 1'b1;
          good      = (cnt < CW'(ERR_LIMIT));
          state_nxt = PH_IDLE;
          cnt_nxt   = '0;
        end else if (cnt >= CW'(WIN)) begin
          done      = 1'b1;
          good      = 1'b0;
          state_nxt = PH_IDLE;
          cnt_nxt   = '0;
        end else begin
          cnt_nxt = cnt + CW'(1);
        end
      end
      default: begin
        state_nxt = PH_IDLE;
        cnt_nxt   = '0;
      end
    endcase
    if (!en) begin
      state_nxt = PH_IDLE;
      cnt_nxt   = '0;
      done      = 1'b0;
      good      = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= PH_IDLE;
      cnt       <= '0;
      cmp.valid <= 1'b0;
      cmp.good  <= 1'b0;
    end else begin
      state     <= state_nxt;
      cnt       <= cnt_nxt;
      cmp.valid <= done;
      cmp.good  <= good;
    end
  end

  assign pump_up = (state == PH_WAIT_VCO);
  assign pump_dn = (state == PH_WAIT_REF);
endmodule

// File: rtl/pld_run_counter.sv
module pld_run_counter
  import pld_pkg::*;
#(
  parameter int LOCK_RUNS = 15
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     en,
  input  cmp_res_t cmp,
  output logic     locked
);
  localparam int RW = $clog2(LOCK_RUNS + 1);
  localparam logic [RW-1:0] RUN_MAX = RW'(LOCK_RUNS);

  logic [RW-1:0] run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= '0;
    end else if (!en) begin
      run <= '0;
    end else if (cmp.valid) begin
      if (!cmp.good)
        run <= '0;
      else if (run != RUN_MAX)
        run <= run + RW'(1);
    end
  end

  assign locked = (run == RUN_MAX);
endmodule

// File: rtl/pld_lock_combine.sv
module pld_lock_combine #(
  parameter int NUM_LOOPS = 2
) (
  input  logic [NUM_LOOPS-1:0] loop_en,
  input  logic [NUM_LOOPS-1:0] loop_lock,
  output logic                 lock_oe,
  output logic                 lock_n
);
  logic [NUM_LOOPS-1:0] loop_ok;

  for (genvar g = 0; g < NUM_LOOPS; g++) begin : g_ok
    assign loop_ok[g] = loop_lock[g] || !loop_en[g];
  end

  assign lock_oe = (|loop_en) && (&loop_ok);
  assign lock_n  = !lock_oe;
endmodule

// File: rtl/dual_lock_detect.sv
module dual_lock_detect
  import pld_pkg::*;
#(
  parameter int NUM_LOOPS = 2,
  parameter int ERR_LIMIT = 3,
  parameter int WIN       = 8,
  parameter int LOCK_RUNS = 15
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LOOPS-1:0] loop_en,
  input  logic [NUM_LOOPS-1:0] ref_edge,
  input  logic [NUM_LOOPS-1:0] vco_edge,
  output logic [NUM_LOOPS-1:0] pump_up,
  output logic [NUM_LOOPS-1:0] pump_dn,
  output logic                 lock_n,
  output logic                 lock_oe
);
  logic [NUM_LOOPS-1:0] cmp_valid;
  logic [NUM_LOOPS-1:0] cmp_good;
  logic [NUM_LOOPS-1:0] loop_lock;

  for (genvar g = 0; g < NUM_LOOPS; g++) begin : g_loop
    cmp_res_t res;

    pld_phase_meter #(
      .ERR_LIMIT (ERR_LIMIT),
      .WIN       (WIN)
    ) u_meter (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (loop_en[g]),
      .ref_edge (ref_edge[g]),
      .vco_edge (vco_edge[g]),
      .pump_up  (pump_up[g]),
      .pump_dn  (pump_dn[g]),
      .cmp      (res)
    );

    pld_run_counter #(
      .LOCK_RUNS (LOCK_RUNS)
    ) u_run (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (loop_en[g]),
      .cmp    (res),
      .locked (loop_lock[g])
    );

    assign cmp_valid[g] = res.valid;
    assign cmp_good[g]  = res.good;
  end

  pld_lock_combine #(
    .NUM_LOOPS (NUM_LOOPS)
  ) u_combine (
    .loop_en   (loop_en),
    .loop_lock (loop_lock),
    .lock_oe   (lock_oe),
    .lock_n    (lock_n)
  );
endmodule

// File: rtl/dual_lock_detect_chk.sv
module dual_lock_detect_chk #(
  parameter int NUM_LOOPS = 2,
  parameter int WIN       = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_LOOPS-1:0] loop_en,
  input logic [NUM_LOOPS-1:0] pump_up,
  input logic [NUM_LOOPS-1:0] pump_dn,
  input logic [NUM_LOOPS-1:0] cmp_valid,
  input logic [NUM_LOOPS-1:0] cmp_good,
  input logic [NUM_LOOPS-1:0] loop_lock,
  input logic                 lock_oe
);
  localparam int LW = $clog2(WIN + 2) + 1;

  // R10
  oe_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_oe |-> (|loop_en));

  // R10
  oe_needs_all_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_oe |-> ((loop_lock & loop_en) == loop_en));

  for (genvar g = 0; g < NUM_LOOPS; g++) begin : g_chk
    logic [LW-1:0] req_len;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        req_len <= '0;
      else if (pump_up[g] || pump_dn[g])
        req_len <= (req_len == {LW{1'b1}}) ? req_len : req_len + LW'(1);
      else
        req_len <= '0;
    end

    // R2
    pump_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({pump_up[g], pump_dn[g]}));

    // R9
    pump_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_len <= LW'(WIN));

    // R7
    bad_drops_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_valid[g] && !cmp_good[g]) |=> !loop_lock[g]);

    // R6
    lock_after_good_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(loop_lock[g]) |-> $past(cmp_valid[g] && cmp_good[g] && loop_en[g]));

    // R8
    lock_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (loop_lock[g] && loop_en[g] && !(cmp_valid[g] && !cmp_good[g])) |=>
        (loop_lock[g] || !loop_en[g]));

    // R11
    off_no_pump_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!loop_en[g] && $past(!loop_en[g])) |-> (!pump_up[g] && !pump_dn[g]));
  end
endmodule

bind dual_lock_detect dual_lock_detect_chk #(
  .NUM_LOOPS (NUM_LOOPS),
  .WIN       (WIN)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .loop_en   (loop_en),
  .pump_up   (pump_up),
  .pump_dn   (pump_dn),
  .cmp_valid (cmp_valid),
  .cmp_good  (cmp_good),
  .loop_lock (loop_lock),
  .lock_oe   (lock_oe)
);

// File: tb/tb_dual_lock_detect.sv
`timescale 1ns/1ps
module tb_dual_lock_detect;
  localparam int WIN  = 8;
  localparam int RUNS = 15;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] loop_en = 2'b00;
  logic [1:0] ref_edge = 2'b00;
  logic [1:0] vco_edge = 2'b00;
  logic [1:0] pump_up, pump_dn;
  logic       lock_n, lock_oe;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;
  int exp_run [2];

  always #4 clk = ~clk;

  dual_lock_detect dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .loop_en  (loop_en),
    .ref_edge (ref_edge),
    .vco_edge (vco_edge),
    .pump_up  (pump_up),
    .pump_dn  (pump_dn),
    .lock_n   (lock_n),
    .lock_oe  (lock_oe)
  );

  function automatic bit exp_oe();
    bit any_on = 1'b0;
    bit all_ok = 1'b1;
    for (int i = 0; i < 2; i++) begin
      if (loop_en[i]) begin
        any_on = 1'b1;
        if (exp_run[i] < RUNS) all_ok = 1'b0;
      end
    end
    return any_on && all_ok;
  endfunction

  function automatic bit cmp_is_good(int mode, int k);
    if (mode == 2) return 1'b1;
    if (k == 0) return 1'b0;
    return (k < 3);
  endfunction

  task automatic check(string req, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic check_lock(string req);
    check(req, "lock_oe", int'(lock_oe), int'(exp_oe()));
    check(req, "lock_n", int'(lock_n), int'(!exp_oe()));
  endtask

  // mode 0: reference first, 1: VCO first, 2: both together; k = 0 means no second pulse
  task automatic run_cmp(int lp, int mode, int k, string req);
    bit act;
    int close;
    act   = loop_en[lp];
    close = (mode == 2) ? 0 : ((k == 0) ? WIN : k);
    @(negedge clk);
    if (mode != 1) ref_edge[lp] = 1'b1;
    if (mode != 0) vco_edge[lp] = 1'b1;
    for (int j = 1; j <= close; j++) begin
      @(negedge clk);
      ref_edge = 2'b00;
      vco_edge = 2'b00;
      check((mode == 0) ? "R2" : "R3", "pump_up", int'(pump_up[lp]), int'(act && mode == 0));
      check((mode == 0) ? "R2" : "R3", "pump_dn", int'(pump_dn[lp]), int'(act && mode == 1));
      if (j == close && k != 0) begin
        if (mode == 0) vco_edge[lp] = 1'b1;
        else           ref_edge[lp] = 1'b1;
      end
    end
    @(negedge clk);
    ref_edge = 2'b00;
    vco_edge = 2'b00;
    check((k == 0 && mode != 2) ? "R9" : "R4", "pump idle after close",
          int'(pump_up[lp] | pump_dn[lp]), 0);
    if (act) begin
      if (cmp_is_good(mode, k)) begin
        if (exp_run[lp] < RUNS) exp_run[lp]++;
      end else begin
        exp_run[lp] = 0;
      end
    end
    @(negedge clk);
    check_lock(req);
  endtask

  task automatic set_en(logic [1:0] m);
    @(negedge clk);
    loop_en = m;
    for (int i = 0; i < 2; i++) if (!m[i]) exp_run[i] = 0;
    @(negedge clk);
    check_lock("R10");
  endtask

  initial begin
    exp_run[0] = 0;
    exp_run[1] = 0;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "lock_oe", int'(lock_oe), 0);
    check("R1", "lock_n", int'(lock_n), 1);
    check("R1", "pumps", int'({pump_up, pump_dn}), 0);
    rst_n = 1'b1;

    set_en(2'b01);
    // R6: 14 good comparisons do not lock, the 15th does
    for (int i = 0; i < 14; i++) run_cmp(0, 0, 1, "R6");
    check("R6", "lock_oe after 14 good", int'(lock_oe), 0);
    run_cmp(0, 1, 2, "R6");
    check("R6", "lock_oe after 15 good", int'(lock_oe), 1);
    // R8: saturation keeps lock
    for (int i = 0; i < 6; i++) run_cmp(0, 2, 0, "R8");
    check("R8", "lock_oe after 21 good", int'(lock_oe), 1);
    // R5/R7: error of 3 is bad and drops lock at once
    run_cmp(0, 0, 3, "R7");
    check("R7", "lock_oe after bad", int'(lock_oe), 0);
    // R5: error of 2 either way is good, VCO first uses pump_dn
    for (int i = 0; i < 15; i++) run_cmp(0, i % 2, 2, "R5");
    check("R5", "lock_oe after error-2 run", int'(lock_oe), 1);
    // R9: missing second pulse is bad
    run_cmp(0, 1, 0, "R9");
    check("R9", "lock_oe after timeout", int'(lock_oe), 0);
    // R4: simultaneous pulses are good
    for (int i = 0; i < 15; i++) run_cmp(0, 2, 0, "R4");
    // R10: other loop enabled but unlocked keeps the pin floating
    set_en(2'b11);
    check("R10", "loop1 unlocked", int'(lock_oe), 0);
    set_en(2'b01);
    check("R10", "loop1 off ignored", int'(lock_oe), 1);
    set_en(2'b00);
    check("R10", "both off", int'(lock_oe), 0);
    // R11: disabled loop ignores pulses, re-enable needs a fresh run
    run_cmp(0, 0, 1, "R11");
    set_en(2'b01);
    check("R11", "re-enabled not locked", int'(lock_oe), 0);
    // random mix
    for (int n = 0; n < 400; n++) begin
      int lp, mode, k;
      if ($urandom_range(0, 19) == 0) set_en(2'($urandom_range(0, 3)));
      lp   = $urandom_range(0, 1);
      mode = $urandom_range(0, 2);
      k    = ($urandom_range(0, 9) < 8) ? $urandom_range(1, 2) : $urandom_range(0, WIN);
      run_cmp(lp, mode, k, "R10");
    end
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end
endmodule